// File: doc/BRIEF.md
# Data-Processing Execute Unit with Condition Flags

This block is the execute stage for the data-processing class of a 32-bit RISC instruction set. Each cycle it may accept one instruction word together with two operand values read from the register file. These are the value of the first source register and the value of the register named by the low four bits of the operand-2 field. It also takes the current condition flags. One clock later it presents the result, a write strobe and index for the destination register, and the condition flags the core should hold from then on.

The word is split, from bit 31 down, into a 4-bit condition (ignored here, since gating is done elsewhere), two bits that must be zero for a data-processing word, an immediate select bit I at bit 25, a 4-bit opcode in bits 24..21, a flag-set bit S at bit 20, a 4-bit first-source index, a 4-bit destination index in bits 15..12 and a 12-bit operand-2 field. A single shared 33-bit adder serves every arithmetic opcode. A separate bitwise unit serves the logical ones.

Flags are packed as {N, Z, C, V} in bits 3..0 of both flag ports. The block stores no flag register of its own. When an instruction does not set flags, the incoming flags are returned unchanged.

Top module: `dp_alu`

## Requirements
- R1: Operand 2 is the 12-bit field zero-extended when instr[25]=1, and `rm_val` when instr[25]=0. `rd_idx` presents instr[15:12].
- R2: Opcode 0100 (add) yields rn+op2. Opcode 0101 (add with carry) yields rn+op2+C.
- R3: Opcode 0010 yields rn-op2. Opcode 0110 yields rn-op2, minus one more when C is 0. Opcode 0011 yields op2-rn.
- R4: Opcodes 1000 (AND test), 1001 (XOR test), 1010 (compare, rn-op2) and 1011 (compare-negative, rn+op2) never raise `rd_wr`, but they do update flags when S=1.
- R5: The logical opcodes give these results: 0000 rn&op2, 0001 rn^op2, 1100 rn|op2, 1101 op2, 1110 rn&~op2, 1111 ~op2. All of them raise `rd_wr`.
- R6: With S=0, `flags_out` equals the `flags_in` that came with the instruction.
- R7: With S=1, N equals result bit 31 and Z is 1 exactly when the result is zero.
- R8: For arithmetic opcodes, C is the adder carry-out, which is the inverse of borrow for subtraction, and V flags signed overflow. For logical and test opcodes, C and V keep their input values.
- R9: A word with instr[27:26] other than 00, or with opcode 0111, gives `rd_wr`=0 and flags equal to `flags_in`, even when S=1.
- R10: Results appear exactly one clock after the accepting edge. `out_valid` follows `in_valid`. With `in_valid`=0, `rd_wr` is 0 and the flags pass through unchanged.
- R11: While `rst` is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Data-processing instruction word |
| rn_val | input | 32 | Value of the first source register |
| rm_val | input | 32 | Value of the register named by instr[3:0] |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| out_valid | output | 1 | Registered copy of in_valid |
| result | output | 32 | Operation result |
| rd_wr | output | 1 | Write strobe for the destination register |
| rd_idx | output | 4 | Destination register index |
| flags_out | output | 4 | Flags {N,Z,C,V} to hold from now on |

## Verification
Every output is produced by a single register stage. The value presented before a rising edge therefore shows up on `result`, `rd_wr`, `rd_idx`, `flags_out` and `out_valid` right after that edge, and it holds for the whole following cycle. The bench applies each stimulus at a falling edge and reads the outputs at the next falling edge, which is half a period after the capturing edge, so no check samples near a clock edge. The embedded properties use the same one-cycle relation: each relates the inputs at one edge to the outputs after the next edge.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
    OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
    OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
    OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
  } dp_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    dp_op_e     op;
    logic       set_flags;
    logic       is_arith;
    logic       wr_rd;
    logic       legal;
    logic [3:0] rd;
  } dec_t;

endpackage

// File: rtl/dp_decode.sv
module dp_decode
  import dpalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] rm_val,
  output dec_t              dec,
  output logic [DATA_W-1:0] op2
);
  localparam int IMM_W = 12;

  logic unused_fields;
  assign unused_fields = ^{instr[31:28], instr[19:16]};

  always_comb begin
    dec.op        = dp_op_e'(instr[24:21]);
    dec.set_flags = instr[20];
    dec.rd        = instr[15:12];
    dec.legal     = (instr[27:26] == 2'b00) && (instr[24:21] != OP_RSC);
    unique case (dec.op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_CMP, OP_CMN: dec.is_arith = 1'b1;
      default:                                                dec.is_arith = 1'b0;
    endcase
    dec.wr_rd = dec.legal && (instr[24:23] != 2'b10);
  end

  always_comb begin
    if (instr[25]) op2 = {{(DATA_W-IMM_W){1'b0}}, instr[IMM_W-1:0]};
    else           op2 = rm_val;
  end

endmodule

// File: rtl/dp_addsub.sv
module dp_addsub
  import dpalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  dp_op_e            op,
  input  logic [DATA_W-1:0] rn,
  input  logic [DATA_W-1:0] op2,
  input  logic              c_in,
  output logic [DATA_W-1:0] sum,
  output logic              c_out,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] xa, yb;
  logic              ci;
  logic [DATA_W:0]   full;

  always_comb begin
    xa = rn;
    yb = op2;
    ci = 1'b0;
    unique case (op)
      OP_ADC:         ci = c_in;
      OP_SUB, OP_CMP: begin yb = ~op2; ci = 1'b1; end
      OP_SBC:         begin yb = ~op2; ci = c_in; end
      OP_RSB:         begin xa = op2; yb = ~rn; ci = 1'b1; end
      default:        ci = 1'b0;
    endcase
  end

  assign full  = {1'b0, xa} + {1'b0, yb} + {{DATA_W{1'b0}}, ci};
  assign sum   = full[MSB:0];
  assign c_out = full[DATA_W];
  assign ovf   = (xa[MSB] == yb[MSB]) && (sum[MSB] != xa[MSB]);

endmodule

// File: rtl/dp_logic.sv
module dp_logic
  import dpalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  dp_op_e            op,
  input  logic [DATA_W-1:0] rn,
  input  logic [DATA_W-1:0] op2,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_AND, OP_TST: res = rn & op2;
      OP_EOR, OP_TEQ: res = rn ^ op2;
      OP_ORR:         res = rn | op2;
      OP_MOV:         res = op2;
      OP_BIC:         res = rn & ~op2;
      OP_MVN:         res = ~op2;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dpalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] rn_val,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [3:0]        flags_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              rd_wr,
  output logic [3:0]        rd_idx,
  output logic [3:0]        flags_out
);
  localparam int MSB = DATA_W - 1;

  dec_t              dec;
  logic [DATA_W-1:0] op2, sum, lres, res_c;
  logic              c_out, ovf, upd;
  flags_t            fin, nf;

  assign fin = flags_t'(flags_in);

  dp_decode #(.DATA_W(DATA_W)) u_dec (
    .instr(instr), .rm_val(rm_val), .dec(dec), .op2(op2)
  );

  dp_addsub #(.DATA_W(DATA_W)) u_add (
    .op(dec.op), .rn(rn_val), .op2(op2), .c_in(fin.c),
    .sum(sum), .c_out(c_out), .ovf(ovf)
  );

  dp_logic #(.DATA_W(DATA_W)) u_log (
    .op(dec.op), .rn(rn_val), .op2(op2), .res(lres)
  );

  always_comb begin
    res_c = dec.is_arith ? sum : lres;
    nf.n  = res_c[MSB];
    nf.z  = (res_c == '0);
    nf.c  = dec.is_arith ? c_out : fin.c;
    nf.v  = dec.is_arith ? ovf   : fin.v;
    upd   = in_valid && dec.legal && dec.set_flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      rd_wr     <= 1'b0;
      rd_idx    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      result    <= res_c;
      rd_wr     <= in_valid && dec.wr_rd;
      rd_idx    <= dec.rd;
      flags_out <= upd ? nf : flags_in;
    end
  end

  // R6: no S bit, flags come back untouched
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !instr[20]) |=> (flags_out == $past(flags_in)));

  // R4: test/compare opcodes never write the destination
  a_r4_no_write: assert property (@(posedge clk) disable iff (rst)
    (instr[24:23] == 2'b10) |=> !rd_wr);

  // R7: N and Z track the registered result when flags are set
  a_r7_nz_match: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[20] && instr[27:26] == 2'b00 && instr[24:21] != 4'b0111)
    |=> (flags_out[3] == result[MSB]) && (flags_out[2] == (result == '0)));

  // R8: logical opcodes keep C and V
  a_r8_logic_cv: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (instr[24:21] inside {4'b0000, 4'b0001, 4'b1000, 4'b1001,
                                       4'b1100, 4'b1101, 4'b1110, 4'b1111}))
    |=> (flags_out[1:0] == $past(flags_in[1:0])));

  // R9: malformed words leave flags and destination alone
  a_r9_illegal: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (instr[27:26] != 2'b00 || instr[24:21] == 4'b0111))
    |=> (!rd_wr && flags_out == $past(flags_in)));

  // R10: idle cycles produce no write and no valid
  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!rd_wr && !out_valid));

endmodule

// File: tb/tb_dp_alu.sv
`timescale 1ns/1ps
module tb_dp_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rn_val = '0;
  logic [31:0] rm_val = '0;
  logic [3:0]  flags_in = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        rd_wr;
  logic [3:0]  rd_idx;
  logic [3:0]  flags_out;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  dp_alu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .rn_val(rn_val), .rm_val(rm_val), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .rd_wr(rd_wr),
    .rd_idx(rd_idx), .flags_out(flags_out)
  );

  function automatic logic [31:0] mk(logic i, logic [3:0] op, logic s,
                                     logic [3:0] rn, logic [3:0] rd, logic [11:0] o2);
    return {4'b1110, 2'b00, i, op, s, rn, rd, o2};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at falling edge, sample at next falling edge (one register stage)
  task automatic issue(logic [31:0] w, logic [31:0] a, logic [31:0] b, logic [3:0] f);
    @(negedge clk);
    in_valid = 1'b1; instr = w; rn_val = a; rm_val = b; flags_in = f;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R11 result", result, 32'd0);
    chk("R11 rd_wr", {31'b0, rd_wr}, 32'd0);
    chk("R11 flags", {28'b0, flags_out}, 32'd0);
  endtask

  task automatic t_add();
    issue(mk(1'b0, 4'b0100, 1'b0, 4'd1, 4'd9, 12'h002), 32'd5, 32'd7, 4'b1010);
    chk("R2 add reg", result, 32'd12);
    chk("R1 rd_idx", {28'b0, rd_idx}, 32'd9);
    chk("R10 out_valid", {31'b0, out_valid}, 32'd1);
    chk("R6 flags held", {28'b0, flags_out}, 32'b1010);
    issue(mk(1'b1, 4'b0100, 1'b1, 4'd6, 4'd4, 12'd42), 32'hFFFF_FFD6, 32'hDEAD, 4'b0000);
    chk("R1 imm add", result, 32'd0);
    chk("R7 R8 adds flags", {28'b0, flags_out}, 32'b0110);
    issue(mk(1'b1, 4'b0101, 1'b1, 4'd1, 4'd2, 12'd2), 32'd1, 32'd0, 4'b0010);
    chk("R2 adc", result, 32'd4);
    chk("R8 adc flags", {28'b0, flags_out}, 32'b0000);
  endtask

  task automatic t_sub();
    issue(mk(1'b0, 4'b0010, 1'b1, 4'd1, 4'd2, 12'h003), 32'd3, 32'd5, 4'b0000);
    chk("R3 sub", result, 32'hFFFF_FFFE);
    chk("R8 sub borrow flags", {28'b0, flags_out}, 32'b1000);
    issue(mk(1'b1, 4'b0110, 1'b1, 4'd1, 4'd2, 12'd3), 32'd10, 32'd0, 4'b0000);
    chk("R3 sbc c0", result, 32'd6);
    chk("R8 sbc flags", {28'b0, flags_out}, 32'b0010);
    issue(mk(1'b1, 4'b0110, 1'b0, 4'd1, 4'd2, 12'd3), 32'd10, 32'd0, 4'b0010);
    chk("R3 sbc c1", result, 32'd7);
    issue(mk(1'b1, 4'b0011, 1'b1, 4'd1, 4'd2, 12'd10), 32'd3, 32'd0, 4'b0000);
    chk("R3 rsb", result, 32'd7);
    chk("R8 rsb flags", {28'b0, flags_out}, 32'b0010);
  endtask

  task automatic t_compare();
    issue(mk(1'b0, 4'b1010, 1'b1, 4'd1, 4'd3, 12'h002), 32'h8000_0000, 32'd1, 4'b0000);
    chk("R4 cmp no write", {31'b0, rd_wr}, 32'd0);
    chk("R8 cmp overflow", {28'b0, flags_out}, 32'b0011);
    issue(mk(1'b1, 4'b1011, 1'b1, 4'd1, 4'd3, 12'd1), 32'h7FFF_FFFF, 32'd0, 4'b0000);
    chk("R4 cmn no write", {31'b0, rd_wr}, 32'd0);
    chk("R8 cmn flags", {28'b0, flags_out}, 32'b1001);
    issue(mk(1'b1, 4'b1000, 1'b1, 4'd0, 4'd3, 12'd8), 32'd5, 32'd0, 4'b0011);
    chk("R4 tst no write", {31'b0, rd_wr}, 32'd0);
    chk("R8 tst keeps cv", {28'b0, flags_out}, 32'b0111);
    issue(mk(1'b0, 4'b1001, 1'b1, 4'd1, 4'd3, 12'h002), 32'h8000_0000, 32'd0, 4'b0000);
    chk("R7 teq sign", {28'b0, flags_out}, 32'b1000);
  endtask

  task automatic t_logic();
    issue(mk(1'b1, 4'b1111, 1'b0, 4'd0, 4'd0, 12'd8), 32'd0, 32'd0, 4'b0000);
    chk("R5 mvn", result, 32'hFFFF_FFF7);
    chk("R5 mvn write", {31'b0, rd_wr}, 32'd1);
    issue(mk(1'b1, 4'b1110, 1'b0, 4'd1, 4'd0, 12'hFF), 32'h1234_5678, 32'd0, 4'b0000);
    chk("R5 bic", result, 32'h1234_5600);
    issue(mk(1'b0, 4'b0000, 1'b0, 4'd1, 4'd0, 12'h002), 32'hF0F0_F0F0, 32'h0FF0_0FF0, 4'b0000);
    chk("R5 and", result, 32'h00F0_00F0);
    issue(mk(1'b0, 4'b0001, 1'b0, 4'd1, 4'd0, 12'h002), 32'hF0F0_F0F0, 32'h0FF0_0FF0, 4'b0000);
    chk("R5 eor", result, 32'hFF00_FF00);
    issue(mk(1'b0, 4'b1100, 1'b0, 4'd1, 4'd0, 12'h002), 32'hF0F0_F0F0, 32'h0FF0_0FF0, 4'b0000);
    chk("R5 orr", result, 32'hFFF0_FFF0);
    issue(mk(1'b0, 4'b1101, 1'b1, 4'd1, 4'd0, 12'h002), 32'h1234, 32'd0, 4'b1011);
    chk("R5 mov", result, 32'd0);
    chk("R7 movs zero", {28'b0, flags_out}, 32'b0111);
  endtask

  task automatic t_illegal();
    logic [31:0] w;
    w = mk(1'b0, 4'b0100, 1'b1, 4'd1, 4'd2, 12'h002);
    w[27:26] = 2'b01;
    issue(w, 32'd1, 32'd1, 4'b0101);
    chk("R9 bad class no write", {31'b0, rd_wr}, 32'd0);
    chk("R9 bad class flags", {28'b0, flags_out}, 32'b0101);
    issue(mk(1'b0, 4'b0111, 1'b1, 4'd1, 4'd2, 12'h002), 32'd0, 32'd0, 4'b1100);
    chk("R9 op0111 no write", {31'b0, rd_wr}, 32'd0);
    chk("R9 op0111 flags", {28'b0, flags_out}, 32'b1100);
  endtask

  task automatic t_idle();
    @(negedge clk);
    in_valid = 1'b0; instr = mk(1'b0, 4'b0100, 1'b1, 4'd1, 4'd2, 12'h002);
    rn_val = 32'd0; rm_val = 32'd0; flags_in = 4'b1001;
    @(negedge clk);
    chk("R10 idle no write", {31'b0, rd_wr}, 32'd0);
    chk("R10 idle valid low", {31'b0, out_valid}, 32'd0);
    chk("R10 idle flags pass", {28'b0, flags_out}, 32'b1001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_add();
    t_sub();
    t_compare();
    t_logic();
    t_illegal();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule